// File: doc/BRIEF.md
# Forwarding Accumulator Pipeline

This block is a two-stage accumulator that runs over a small bank of registers. Each cycle it takes one instruction: a register index, a data operand, a clear flag and a nop flag. In the execute stage it reads the indexed register and either replaces that value with the operand (clear) or adds the operand to it. The result goes into a staging register. In the next stage the staging register is written back into the bank. The staging register also drives the output port.

A register is written back one edge later than it is read. A second instruction to the same register that follows directly would therefore read a stale value. To prevent this, the block stores the index and the validity of the instruction now in the staging register. When the incoming index equals that stored index and the stored instruction was not a nop, the operand comes from the staging register. Otherwise it comes from the bank. Nops bring in no new work, so a short run of them drains the pipeline. After such a run, every register holds what a non-pipelined accumulator would hold for the same instruction stream.

Top module: `fwd_accum`

## Requirements
- R1: While reset is asserted, and right after it is released, out_o is 0 and every register in the bank reads as 0.
- R2: A non-nop instruction with clr_i=1 produces data_i as its result, even when forwarding applies.
- R3: A non-nop instruction with clr_i=0 produces the selected operand plus data_i, modulo 2^DW. For example, 0x8000+0x8000 gives 0x0000.
- R4: The result of a non-nop instruction presented before a rising edge appears on out_o right after that edge.
- R5: A nop instruction (nop_i=1) leaves out_o unchanged and causes no register write at the following write-back edge. This holds whatever the values of clr_i, addr_i and data_i are.
- R6: When an instruction follows a non-nop instruction to the same address with no gap, it uses the previous result as its operand.
- R7: When a nop separates two instructions to the same address, the second one gets the first one's result from the bank.
- R8: When back-to-back instructions go to different addresses, the second one uses the bank value of its own address.
- R9: After a run of at least one nop, the bank contents equal those of a non-pipelined accumulator fed the same instructions. The bench reads each register with a clr_i=0, data_i=0 instruction.
- R10: An instruction two slots after a write to the same address, with a different address in between, sees the written-back value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Register index of the instruction |
| data_i | input | DW | Data operand |
| clr_i | input | 1 | 1: result is data_i; 0: result is operand plus data_i |
| nop_i | input | 1 | 1: instruction is a nop |
| out_o | output | DW | Staging register: result of the latest non-nop instruction |

## Verification
The assertions check four things on every cycle: a clear loads the operand, a nop freezes the output, a nop causes no write-back, and at most one register is written per edge. They also check the back-to-back forwarding sum at the ports, whatever the data values are. Three behaviours depend on bank contents that the ports do not show, so only the bench scenarios can demonstrate them: correct operands for different-address and nop-separated sequences, wraparound at the bank, and the match between the drained bank and a non-pipelined model. The bench shows these by reading every register back after a flush and again after a reset in the middle of the run.

// File: rtl/accum_pkg.sv
package accum_pkg;
  typedef enum logic {
    SRC_BANK  = 1'b0,
    SRC_STAGE = 1'b1
  } opnd_src_e;
endpackage

// File: rtl/accum_rf.sv
module accum_rf #(
  parameter int AW = 3,
  parameter int DW = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [DW-1:0]      wr_data_i,
  input  logic [AW-1:0]      rd_addr_i,
  output logic [DW-1:0]      rd_data_o,
  output logic [(1<<AW)-1:0] wr_vec_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_dec
    assign wr_vec_o[g] = wr_en_i && (wr_addr_i == AW'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (wr_vec_o[i]) mem_q[i] <= wr_data_i;
    end
  end

  // read sees the bank as it stood before this edge's write-back
  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/accum_fwd.sv
module accum_fwd
  import accum_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          nop_i,
  output logic [AW-1:0] prev_addr_o,
  output logic          prev_vld_o,
  output opnd_src_e     src_o
);
  logic [AW-1:0] prev_addr_q;
  logic          prev_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_addr_q <= '0;
      prev_vld_q  <= 1'b0;
    end else begin
      prev_addr_q <= addr_i;
      prev_vld_q  <= !nop_i;
    end
  end

  assign prev_addr_o = prev_addr_q;
  assign prev_vld_o  = prev_vld_q;
  assign src_o = (prev_vld_q && (addr_i == prev_addr_q)) ? SRC_STAGE : SRC_BANK;
endmodule

// File: rtl/accum_exec.sv
module accum_exec
  import accum_pkg::*;
#(
  parameter int DW = 16
) (
  input  opnd_src_e     src_i,
  input  logic [DW-1:0] bank_i,
  input  logic [DW-1:0] stage_i,
  input  logic [DW-1:0] data_i,
  input  logic          clr_i,
  output logic [DW-1:0] result_o
);
  logic [DW-1:0] opnd;

  always_comb begin
    opnd     = (src_i == SRC_STAGE) ? stage_i : bank_i;
    result_o = clr_i ? data_i : DW'(opnd + data_i);
  end
endmodule

// File: rtl/fwd_accum.sv
module fwd_accum
  import accum_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          clr_i,
  input  logic          nop_i,
  output logic [DW-1:0] out_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    rd_data;
  logic [DW-1:0]    result;
  logic [DW-1:0]    stage_q;
  logic [AW-1:0]    prev_addr;
  logic             prev_vld;
  logic [DEPTH-1:0] wr_vec;
  opnd_src_e        src;

  accum_fwd #(.AW(AW)) u_fwd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .nop_i      (nop_i),
    .prev_addr_o(prev_addr),
    .prev_vld_o (prev_vld),
    .src_o      (src)
  );

  // stage_q belongs to the instruction tracked by prev_addr/prev_vld
  accum_rf #(.AW(AW), .DW(DW)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (prev_vld),
    .wr_addr_i(prev_addr),
    .wr_data_i(stage_q),
    .rd_addr_i(addr_i),
    .rd_data_o(rd_data),
    .wr_vec_o (wr_vec)
  );

  accum_exec #(.DW(DW)) u_exec (
    .src_i   (src),
    .bank_i  (rd_data),
    .stage_i (stage_q),
    .data_i  (data_i),
    .clr_i   (clr_i),
    .result_o(result)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stage_q <= '0;
    else if (!nop_i) stage_q <= result;
  end

  assign out_o = stage_q;
endmodule

// File: rtl/fwd_accum_chk.sv
module fwd_accum_chk #(
  parameter int AW = 3,
  parameter int DW = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [AW-1:0]      addr_i,
  input logic [DW-1:0]      data_i,
  input logic               clr_i,
  input logic               nop_i,
  input logic [DW-1:0]      out_o,
  input logic [(1<<AW)-1:0] wr_vec
);
  typedef logic [DW-1:0] word_t;

  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assert_reset_out_R1: assert property (@(posedge clk_i)
    !rst_ni |-> out_o == '0);

  assert_clear_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nop_i && clr_i) |=> out_o == $past(data_i));

  assert_nop_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nop_i |=> $stable(out_o));

  assert_nop_no_wb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(nop_i)) |-> wr_vec == '0);

  assert_single_wb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_vec));

  assert_fwd_sum_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !nop_i && !clr_i && !$past(nop_i) && addr_i == $past(addr_i))
    |=> out_o == word_t'($past(out_o) + $past(data_i)));
endmodule

bind fwd_accum fwd_accum_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .addr_i(addr_i),
  .data_i(data_i),
  .clr_i (clr_i),
  .nop_i (nop_i),
  .out_o (out_o),
  .wr_vec(wr_vec)
);

// File: tb/sim_fwd_accum.sv
module sim_fwd_accum;
  localparam int AW = 3;
  localparam int DW = 16;
  localparam int NREG = 1 << AW;
  localparam int NVEC = 13;

  // {nop[36], clr[35], addr[34:32], data[31:16], expected out[15:0]}
  localparam logic [36:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 3'd2, 16'h0005, 16'h0005},  // R2 clear
    {1'b0, 1'b0, 3'd2, 16'h0003, 16'h0008},  // R6 forward
    {1'b0, 1'b0, 3'd2, 16'h0001, 16'h0009},  // R6 forward again
    {1'b0, 1'b0, 3'd5, 16'h0010, 16'h0010},  // R8 other address
    {1'b0, 1'b0, 3'd2, 16'h0002, 16'h000B},  // R10 two slots later
    {1'b1, 1'b0, 3'd2, 16'h7777, 16'h000B},  // R5 nop holds
    {1'b0, 1'b0, 3'd2, 16'h0004, 16'h000F},  // R7 after nop
    {1'b0, 1'b0, 3'd5, 16'hFFF5, 16'h0005},  // R3 wrap
    {1'b0, 1'b1, 3'd5, 16'h1234, 16'h1234},  // R2 clear over forward
    {1'b0, 1'b0, 3'd7, 16'h8000, 16'h8000},  // R3
    {1'b0, 1'b0, 3'd7, 16'h8000, 16'h0000},  // R3 wrap with forward
    {1'b1, 1'b1, 3'd7, 16'h5555, 16'h0000},  // R5 nop with clear
    {1'b1, 1'b0, 3'd0, 16'h0000, 16'h0000}   // R9 flush
  };

  logic          clk = 1'b0;
  logic          rst_ni;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;
  logic          clr;
  logic          nop;
  logic [DW-1:0] out;

  logic [DW-1:0] ref_rf [NREG];
  logic [DW-1:0] ref_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fwd_accum #(.AW(AW), .DW(DW)) u0 (
    .clk_i (clk),
    .rst_ni(rst_ni),
    .addr_i(addr),
    .data_i(data),
    .clr_i (clr),
    .nop_i (nop),
    .out_o (out)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // non-pipelined reference updates at once
  task automatic issue(logic n, logic c, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    nop = n; clr = c; addr = a; data = d;
    @(posedge clk);
    #1;
    if (!n) begin
      ref_out = c ? d : DW'(ref_rf[a] + d);
      ref_rf[a] = ref_out;
    end
  endtask

  task automatic read_all(string req);
    for (int i = 0; i < NREG; i++) begin
      issue(1'b0, 1'b0, AW'(i), '0);
      check(req, out, ref_rf[i]);
    end
    issue(1'b1, 1'b0, '0, '0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    nop = 1'b1; clr = 1'b0; addr = '0; data = '0;
    for (int i = 0; i < NREG; i++) ref_rf[i] = '0;
    ref_out = '0;
    @(posedge clk);
    #1;
    check("R1 out in reset", out, '0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    rst_ni = 1'b1;
    #1;
    do_reset();
    check("R1 out after reset", out, '0);
    read_all("R1 bank zero");

    for (int v = 0; v < NVEC; v++) begin
      issue(VEC[v][36], VEC[v][35], VEC[v][34:32], VEC[v][31:16]);
      check("R4 table out", out, VEC[v][15:0]);
      check("R4 model out", out, ref_out);
    end
    issue(1'b1, 1'b0, '0, '0);
    read_all("R9 drained bank");

    // R5: nop with other fields set writes nothing
    issue(1'b0, 1'b1, 3'd3, 16'h00AA);
    issue(1'b1, 1'b1, 3'd3, 16'hBEEF);
    check("R5 nop holds", out, 16'h00AA);
    issue(1'b1, 1'b0, 3'd4, 16'h1111);
    read_all("R5 bank untouched by nop");

    // R8/R10: alternating addresses
    issue(1'b0, 1'b0, 3'd1, 16'h0100);
    issue(1'b0, 1'b0, 3'd6, 16'h0200);
    issue(1'b0, 1'b0, 3'd1, 16'h0001);
    check("R10 alternating", out, 16'h0101);
    issue(1'b0, 1'b0, 3'd6, 16'h0002);
    check("R8 alternating", out, 16'h0202);
    issue(1'b1, 1'b0, '0, '0);
    read_all("R9 after alternating");

    // R1: reset mid-run
    issue(1'b0, 1'b0, 3'd4, 16'h0042);
    do_reset();
    check("R1 out after mid reset", out, '0);
    read_all("R1 bank after mid reset");

    finish_run();
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finish");
    finish_run();
  end
endmodule